// File: doc/BRIEF.md
# Multi-Channel PWM Timer with Batched Reload

This block is a 16-bit up-counting PWM generator. One cycle register sets the length of the PWM period and three duty registers set how long each of three outputs stays high in every period. The counter runs from zero up to the active cycle value and then returns to zero. Each output is high while the counter is below that output's active duty value. A count-enable input gates every step, so the counter can run from a prescaled tick.

Software reaches the four registers through a simple write port (address, data, strobe). A write only changes a staging copy. Writing the first duty register arms a batched reload. At the next counter clear, all four staging values move into the active compare buffers in the same clock edge. This allows a new period and new duties to be prepared in any order and applied together without glitches. A one-cycle pulse marks every clear, and a status bit shows that an armed reload has not yet taken place.

A small two-state machine controls the reload. In `ST_IDLE`, the transition `ARM` (a write to address 1) moves it to `ST_ARMED`. In `ST_ARMED`, the transition `LOAD` (a counter clear with no new arming write in the same cycle) copies the staging values and returns it to `ST_IDLE`. A clear that coincides with an arming write still loads, and the machine stays in `ST_ARMED`.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset, the counter, all four staging registers and all four active buffers are zero. `reload_pending` is 0, `period_irq` is 0 and all of `pwm_out` is low.
- R2: With `cnt_en` high, the counter increases by one per clock. In the cycle where it equals the active period, it returns to 0 on the next edge, so one period lasts period+1 enabled clocks.
- R3: `pwm_out[k]` is high exactly while the counter is below active duty k+1 (address 1 drives bit 0, address 2 drives bit 1, address 3 drives bit 2). Duty 0 gives a constant low, and a duty above the period gives a constant high.
- R4: A write to address 0 (cycle) or to addresses 1 to 3 (duties) changes only the staging register. Without an arming write, the outputs and the period do not change.
- R5: A write to address 1 arms a reload, and `reload_pending` reads 1 from the next cycle onward.
- R6: When armed, the edge at which the counter clears copies all four staging values into the active buffers at once. `reload_pending` drops at that same edge.
- R7: Rewriting address 1 with its unchanged value arms a reload, which applies a staged cycle change or staged changes to duties 2 and 3.
- R8: Each counter clear produces a `period_irq` pulse. The pulse is high for exactly the one clock after the clearing edge, while the counter reads 0.
- R9: While `cnt_en` is low, the counter holds, no clear occurs, no pulse is produced, and a pending reload stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter step enable (prescaler tick) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 cycle, 1..3 duty of outputs 0..2 |
| wr_data | input | 16 | Write data |
| pwm_out | output | 3 | PWM outputs |
| period_irq | output | 1 | One-cycle pulse after each counter clear |
| reload_pending | output | 1 | Armed reload not yet applied |

## Verification
The bench targets writes to the cycle and duty registers that are never armed. A design that bypasses staging would change the waveform immediately. It also arms a reload while the count is stalled, where a design that loads on a match rather than on a real clear would apply the values early and drop the pending bit. It runs a zero period, where the counter clears on every enabled clock, and it uses duty values of zero and above the period. A comparison error at those edges would give a one-cycle sliver or a missing high cycle. Interrupt pulses are counted over a fixed window to catch a period that is one clock too long or too short.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } reload_st_e;

endpackage

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             irq
);

    // A clear happens only on an enabled step that reaches the period.
    always_comb begin
        wrap = cnt_en && (cnt == period);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (cnt_en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap;
        end
    end

    // R9: a stalled counter holds its value.
    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt));

    // R2: a match with the enable high restarts the count.
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt == period) |=> (cnt == '0));

    // R8: the pulse only appears in the cycle the counter reads zero.
    a_r8_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0));

endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_DUTY = 3,
    parameter int ADDR_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic                           wrap,
    output logic [CNT_W-1:0]               act_period,
    output logic [NUM_DUTY-1:0][CNT_W-1:0] act_duty,
    output logic                           pending
);

    localparam int NUM_REGS = NUM_DUTY + 1;
    localparam int ARM_IDX  = 1;

    reload_st_e state, state_nxt;
    logic       arm_wr;
    logic       load;

    logic [CNT_W-1:0] stg [NUM_REGS];

    always_comb begin
        arm_wr = wr_en && (wr_addr == ADDR_W'(ARM_IDX));
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transition process: ARM and LOAD.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (arm_wr) begin
                    state_nxt = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (wrap && !arm_wr) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Output process.
    always_comb begin
        load    = 1'b0;
        pending = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load    = 1'b0;
                pending = 1'b0;
            end
            ST_ARMED: begin
                load    = wrap;
                pending = 1'b1;
            end
            default: begin
                load    = 1'b0;
                pending = 1'b0;
            end
        endcase
    end

    // Staging registers: address 0 is the cycle, then one per duty.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[k] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
                stg[k] <= wr_data;
            end
        end
    end

    // Active buffers: all loaded on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
        end else if (load) begin
            act_period <= stg[0];
        end
    end

    for (genvar d = 0; d < NUM_DUTY; d++) begin : g_active
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_duty[d] <= '0;
            end else if (load) begin
                act_duty[d] <= stg[d+1];
            end
        end
    end

    // R5: an arming write makes the status visible next cycle.
    a_r5_arm_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> pending);

    // R6: a clear while armed (without a fresh arm) ends the pending state.
    a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wrap && !arm_wr) |=> !pending);

    // R4: active period only moves on a load.
    a_r4_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_period));

    // R6: the period buffer takes the staged value at the load edge.
    a_r6_period_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act_period == $past(stg[0])));

endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    output logic             out
);

    always_comb begin
        out = (cnt < duty);
    end

    // R3: an output that is high cannot be low again until the counter restarts.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out) && $stable(duty)) |-> (cnt != '0));

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
    parameter int CNT_W    = 16,
    parameter int NUM_DUTY = 3,
    parameter int ADDR_W   = $clog2(NUM_DUTY + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [NUM_DUTY-1:0] pwm_out,
    output logic                period_irq,
    output logic                reload_pending
);

    logic [CNT_W-1:0]               cnt;
    logic                           wrap;
    logic [CNT_W-1:0]               act_period;
    logic [NUM_DUTY-1:0][CNT_W-1:0] act_duty;

    pwm_reload_ctrl #(
        .CNT_W    (CNT_W),
        .NUM_DUTY (NUM_DUTY),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wrap       (wrap),
        .act_period (act_period),
        .act_duty   (act_duty),
        .pending    (reload_pending)
    );

    pwm_cycle_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_en (cnt_en),
        .period (act_period),
        .cnt    (cnt),
        .wrap   (wrap),
        .irq    (period_irq)
    );

    for (genvar d = 0; d < NUM_DUTY; d++) begin : g_chan
        pwm_duty_cmp #(
            .CNT_W (CNT_W)
        ) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt),
            .duty  (act_duty[d]),
            .out   (pwm_out[d])
        );

        // R3: a duty beyond the period keeps its output high all period.
        a_r3_full_high: assert property (@(posedge clk) disable iff (!rst_n)
            (act_duty[d] > act_period) |-> pwm_out[d]);
    end

    // R2: the counter never passes the active period.
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period);

endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int ND = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [ND-1:0] pwm_out;
    logic          period_irq;
    logic          reload_pending;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_reload_timer uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_en         (cnt_en),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .pwm_out        (pwm_out),
        .period_irq     (period_irq),
        .reload_pending (reload_pending)
    );

    typedef struct packed {
        logic [ND-1:0] pwm;
        logic          irq;
        logic          pend;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input string req, input string what, input int got, input int expv);
        n_checks++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Behavioural model built from the requirements; pushes one expected item per edge.
    logic [W-1:0] m_cnt, m_per;
    logic [W-1:0] m_duty [ND];
    logic [W-1:0] m_stg [ND+1];
    logic         m_armed, m_irq;

    always @(posedge clk) begin
        exp_t e;
        logic w;
        if (!rst_n) begin
            m_cnt = '0; m_per = '0; m_armed = 1'b0; m_irq = 1'b0;
            for (int j = 0; j < ND; j++) m_duty[j] = '0;
            for (int j = 0; j <= ND; j++) m_stg[j] = '0;
            exp_q.delete();
        end else begin
            w = cnt_en && (m_cnt == m_per);
            if (w && m_armed) begin
                m_per = m_stg[0];
                for (int j = 0; j < ND; j++) m_duty[j] = m_stg[j+1];
                m_armed = 1'b0;
            end
            if (wr_en) begin
                m_stg[wr_addr] = wr_data;
                if (wr_addr == 2'd1) m_armed = 1'b1;
            end
            m_irq = w;
            if (w) m_cnt = '0;
            else if (cnt_en) m_cnt = m_cnt + 1'b1;
            for (int j = 0; j < ND; j++) e.pwm[j] = (m_cnt < m_duty[j]);
            e.irq  = m_irq;
            e.pend = m_armed;
            exp_q.push_back(e);
        end
    end

    // Monitor: pops the expected item and compares away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(cur_req, "pwm_out", int'(pwm_out), int'(e.pwm));
            check(cur_req, "period_irq", int'(period_irq), int'(e.irq));
            check(cur_req, "reload_pending", int'(reload_pending), int'(e.pend));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!period_irq) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int cnt_irq;
        logic any1, all2;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "pwm_out", int'(pwm_out), 0);
        check("R1", "reload_pending", int'(reload_pending), 0);
        check("R1", "period_irq", int'(period_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cnt_en = 1'b1;
        idle(4);

        // R4: staged writes without arming leave the waveform alone
        cur_req = "R4";
        wr(2'd0, 16'd9);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd20);
        idle(30);
        check("R4", "pwm_out unarmed", int'(pwm_out), 0);
        check("R4", "reload_pending unarmed", int'(reload_pending), 0);

        // R5/R6: arming write then load at the next clear (period 0 clears every clock)
        cur_req = "R5";
        wr(2'd1, 16'd4);
        check("R5", "reload_pending after arm", int'(reload_pending), 1);
        @(negedge clk);
        check("R6", "reload_pending after load", int'(reload_pending), 0);
        check("R6", "pwm_out all loaded", int'(pwm_out), 7);
        check("R8", "period_irq at load clear", int'(period_irq), 1);

        // R2/R3: running waveform with period 9, duties 4,3,20
        cur_req = "R2/R3";
        idle(40);

        // R8: pulses per window with period 9 -> 10 clocks per cycle
        cur_req = "R8";
        cnt_irq = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (period_irq) cnt_irq++;
        end
        check("R8", "irq count in 50 clocks (period 9)", cnt_irq, 5);

        // R9: stalled counter keeps a pending reload pending and gives no pulse
        cur_req = "R9";
        @(negedge clk);
        cnt_en = 1'b0;
        wr(2'd1, 16'd4);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 19) begin
                check("R9", "reload_pending while stalled", int'(reload_pending), 1);
                check("R9", "period_irq while stalled", int'(period_irq), 0);
            end
        end
        cnt_en = 1'b1;
        wait_irq();
        check("R9", "reload_pending after resume", int'(reload_pending), 0);

        // R9: gapped enable pattern
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            cnt_en = (i % 3) != 0;
        end
        cnt_en = 1'b1;
        idle(2);

        // R7: change only the cycle, then rewrite address 1 unchanged
        cur_req = "R7";
        wr(2'd0, 16'd5);
        idle(25);
        check("R7", "reload_pending before rewrite", int'(reload_pending), 0);
        wr(2'd1, 16'd4);
        wait_irq();
        cnt_irq = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (period_irq) cnt_irq++;
        end
        check("R7", "irq count in 60 clocks (period 5)", cnt_irq, 10);

        // R7/R3: change only duties 2 and 3 to 0 and above the period
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd6);
        wr(2'd1, 16'd4);
        wait_irq();
        cur_req = "R3";
        any1 = 1'b0; all2 = 1'b1;
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            any1 = any1 | pwm_out[1];
            all2 = all2 & pwm_out[2];
        end
        check("R3", "duty 0 output ever high", int'(any1), 0);
        check("R3", "duty above period always high", int'(all2), 1);

        // R3: duty equal to period leaves exactly one low clock per cycle
        cur_req = "R3";
        wr(2'd1, 16'd5);
        wait_irq();
        idle(30);

        cur_req = "R1";
        idle(3);
        finish_run();
    end

endmodule